// File: doc/BRIEF.md
# Coherent Cache Line Controller

This block is the per-cache state machine for one shared data line in a directory-based invalidation protocol. The line can be held with write permission (E), with read-only permission (S), or not at all (I). A local requester issues read, write and evict commands and gets one acknowledgment pulse for each. The controller sends requests, unblocks and writebacks to the directory. It exchanges invalidation acknowledgments and owner data directly with peer caches. All protocol messages use a single-entry valid/ready message port in each direction.

The controller keeps the local copy of the data and a signed counter of pending invalidation acknowledgments. Transient states cover three waits: a read waiting for data, a write waiting for data and acknowledgments, and an eviction waiting for the directory to confirm it. These states also resolve races. An invalidation can arrive while a request is outstanding. An invalidation can also cross the controller's own writeback. Invalidation acknowledgments may arrive before the directory's data reply.

Top module: `coh_line_ctrl`

## Requirements
- R1: After reset the line is in I, `cmd_ready` and `in_ready` are 1, and `out_valid` and `rsp_valid` are 0.
- R2: A read command (op 0) in I or S sends type 1 (read request) to the directory ID (NCACHE). A later type 3 (directory data) reply stores its data, sends type 9 (read unblock) to the directory, and pulses `rsp_valid` with kind 0 and the received data. The line then enters S.
- R3: A write command (op 1) in I or S sends type 2 (write request) to the directory. A type 3 reply with `in_cnt` equal to 0 stores the command's write data, sends type 10 (write unblock), and pulses kind 1 with that data. The line then enters E.
- R4: When a type 3 reply carries `in_cnt` = N > 0, the write completes only after N type 8 (invalidation acknowledgment) messages have arrived. The acknowledgments may come before or after the data reply, in any split. No unblock and no response appear before the last of them.
- R5: A type 6 (invalidate) message in I, S, or a read-wait or write-wait state sends type 8 to the requester named in `in_src` and leaves the line in I or still waiting.
- R6: Type 6 in E sends type 4 (peer data) with the line data to the requester in `in_src`, then type 5 (owner data) to the directory, and the line enters I. Type 7 (shared invalidate) does the same but leaves the line in S.
- R7: An evict command (op 2) in S or I pulses kind 2 with data 0 at once and sends no message.
- R8: An evict in E sends type 11 (writeback) carrying the line data to the directory. After type 12 (writeback done) it pulses kind 2 and enters I.
- R9: A type 6 arriving while a writeback is outstanding completes the eviction exactly like type 12, and no message is sent.
- R10: A type 4 (peer data) reply completes a pending read with the received data, or a pending write with the command's data, regardless of any acknowledgment count.
- R11: `cmd_ready` is 0 while a transaction is pending or an outbound message is waiting.
- R12: In E, a read pulses kind 0 with the line data and a write updates the line and pulses kind 1 with the new data, both without sending any message.
- R13: While `out_valid` is 1 and `out_ready` is 0, the outbound type, destination and data hold steady and `in_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Requester command valid |
| cmd_ready | output | 1 | Command accepted this cycle when high with cmd_valid |
| cmd_op | input | 2 | 0 read, 1 write, 2 evict |
| cmd_wdata | input | DW | Write data |
| rsp_valid | output | 1 | One-cycle acknowledgment pulse |
| rsp_kind | output | 2 | Acknowledged operation (0 read, 1 write, 2 evict) |
| rsp_data | output | DW | Read data, written data, or 0 for evict |
| in_valid | input | 1 | Inbound message valid |
| in_ready | output | 1 | Inbound message accepted when high with in_valid |
| in_type | input | 4 | Inbound message type |
| in_src | input | IDW | Sender, or the requester for invalidations |
| in_data | input | DW | Inbound data |
| in_cnt | input | CNTW | Acknowledgment count on a directory data reply |
| out_valid | output | 1 | Outbound message valid |
| out_ready | input | 1 | Outbound message taken |
| out_type | output | 4 | Outbound message type |
| out_dst | output | IDW | Destination ID |
| out_data | output | DW | Outbound data |

## Verification
The assertions assume the environment offers at most one inbound message per cycle. They also assume the acknowledgment count on a reply never exceeds the number of peers, and that early acknowledgments never exceed one fewer than the cache count, so the counter stays within range. The stimulus keeps a single transaction in flight and sends only messages the protocol can produce for the current state. It sweeps every acknowledgment count from 0 to 3 with every split between early and late acknowledgments. It drains each outbound message before issuing the next command.

// File: rtl/coh_pkg.sv
package coh_pkg;
  localparam logic [3:0] MSG_REQ_S    = 4'd1;
  localparam logic [3:0] MSG_REQ_E    = 4'd2;
  localparam logic [3:0] MSG_DATA_D2C = 4'd3;
  localparam logic [3:0] MSG_DATA_C2C = 4'd4;
  localparam logic [3:0] MSG_DATA_C2D = 4'd5;
  localparam logic [3:0] MSG_INV      = 4'd6;
  localparam logic [3:0] MSG_INV_S    = 4'd7;
  localparam logic [3:0] MSG_INV_ACK  = 4'd8;
  localparam logic [3:0] MSG_UNBLK_S  = 4'd9;
  localparam logic [3:0] MSG_UNBLK_E  = 4'd10;
  localparam logic [3:0] MSG_WBACK    = 4'd11;
  localparam logic [3:0] MSG_WB_DONE  = 4'd12;

  localparam logic [1:0] OP_RD = 2'd0;
  localparam logic [1:0] OP_WR = 2'd1;
  localparam logic [1:0] OP_EV = 2'd2;

  typedef enum logic [2:0] {ST_I, ST_S, ST_E, ST_IS, ST_IM, ST_EI, ST_FWD} line_st_t;
endpackage

// File: rtl/coh_ack_ctr.sv
module coh_ack_ctr #(
  parameter int CNTW = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            sub,
  input  logic            inc,
  input  logic [CNTW-1:0] amt,
  output logic            nxt_zero
);
  localparam int CW = CNTW + 1;
  localparam logic signed [CW-1:0] CNT_MAX = {1'b0, {(CW-1){1'b1}}};

  logic signed [CW-1:0] cnt, sum_n;

  always_comb begin
    sum_n = cnt;
    if (inc) sum_n = sum_n + {{(CW-1){1'b0}}, 1'b1};
    if (sub) sum_n = sum_n - $signed({1'b0, amt});
  end

  assign nxt_zero = (sum_n == '0);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else            cnt <= sum_n;
  end

  // R4
  ctr_span_chk: assert property (@(posedge clk) disable iff (rst)
    inc && !sub |-> cnt != CNT_MAX);
endmodule

// File: rtl/coh_msg_out.sv
module coh_msg_out #(
  parameter int IDW = 3,
  parameter int DW  = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ld,
  input  logic [3:0]     ld_type,
  input  logic [IDW-1:0] ld_dst,
  input  logic [DW-1:0]  ld_data,
  input  logic           out_ready,
  output logic           out_valid,
  output logic [3:0]     out_type,
  output logic [IDW-1:0] out_dst,
  output logic [DW-1:0]  out_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_type  <= '0;
      out_dst   <= '0;
      out_data  <= '0;
    end else if (ld) begin
      out_valid <= 1'b1;
      out_type  <= ld_type;
      out_dst   <= ld_dst;
      out_data  <= ld_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R13
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_type) && $stable(out_dst) && $stable(out_data));
  // R13
  out_load_chk: assert property (@(posedge clk) disable iff (rst)
    ld |-> !out_valid);
endmodule

// File: rtl/coh_line_fsm.sv
module coh_line_fsm
  import coh_pkg::*;
#(
  parameter int DW     = 8,
  parameter int IDW    = 3,
  parameter int DIR_ID = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cmd_valid,
  output logic           cmd_ready,
  input  logic [1:0]     cmd_op,
  input  logic [DW-1:0]  cmd_wdata,
  output logic           rsp_valid,
  output logic [1:0]     rsp_kind,
  output logic [DW-1:0]  rsp_data,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [3:0]     in_type,
  input  logic [IDW-1:0] in_src,
  input  logic [DW-1:0]  in_data,
  input  logic           out_busy,
  output logic           ld,
  output logic [3:0]     ld_type,
  output logic [IDW-1:0] ld_dst,
  output logic [DW-1:0]  ld_data,
  output logic           ctr_clr,
  output logic           ctr_sub,
  output logic           ctr_inc,
  input  logic           ctr_nxt_zero
);
  localparam logic [IDW-1:0] DIR = IDW'(DIR_ID);

  line_st_t st_q, st_n, fwd_q, fwd_n;
  logic [DW-1:0] data_q, data_n, wpend_q, wpend_n, rd_n;
  logic have_q, have_n, rv_n, stable, take_msg, take_cmd;
  logic [1:0] rk_n;

  assign stable    = (st_q == ST_I) || (st_q == ST_S) || (st_q == ST_E);
  assign in_ready  = !out_busy && (st_q != ST_FWD);
  assign cmd_ready = stable && !out_busy && !in_valid;
  assign take_msg  = in_valid && in_ready;
  assign take_cmd  = cmd_valid && cmd_ready;
  assign ctr_inc   = take_msg && (st_q == ST_IM) && (in_type == MSG_INV_ACK);
  assign ctr_sub   = take_msg && (st_q == ST_IM) && (in_type == MSG_DATA_D2C);
  assign ctr_clr   = take_cmd;

  always_comb begin
    st_n = st_q; fwd_n = fwd_q; data_n = data_q; wpend_n = wpend_q; have_n = have_q;
    ld = 1'b0; ld_type = MSG_REQ_S; ld_dst = DIR; ld_data = data_q;
    rv_n = 1'b0; rk_n = OP_RD; rd_n = '0;
    if (st_q == ST_FWD) begin
      if (!out_busy) begin
        ld = 1'b1; ld_type = MSG_DATA_C2D; st_n = fwd_q;
        if (fwd_q == ST_I) data_n = '0;
      end
    end else if (take_msg) begin
      if (in_type == MSG_INV && st_q != ST_E && st_q != ST_EI) begin
        ld = 1'b1; ld_type = MSG_INV_ACK; ld_dst = in_src;
        if (stable) begin st_n = ST_I; data_n = '0; end
      end else begin
        case (st_q)
          ST_E: if (in_type == MSG_INV || in_type == MSG_INV_S) begin
            ld = 1'b1; ld_type = MSG_DATA_C2C; ld_dst = in_src;
            st_n = ST_FWD; fwd_n = (in_type == MSG_INV) ? ST_I : ST_S;
          end
          ST_IS: if (in_type == MSG_DATA_D2C || in_type == MSG_DATA_C2C) begin
            data_n = in_data; st_n = ST_S;
            ld = 1'b1; ld_type = MSG_UNBLK_S;
            rv_n = 1'b1; rk_n = OP_RD; rd_n = in_data;
          end
          ST_IM: begin
            if (in_type == MSG_DATA_D2C) have_n = 1'b1;
            if (in_type == MSG_DATA_C2C ||
                (in_type == MSG_DATA_D2C && ctr_nxt_zero) ||
                (in_type == MSG_INV_ACK && have_q && ctr_nxt_zero)) begin
              data_n = wpend_q; st_n = ST_E; have_n = 1'b0;
              ld = 1'b1; ld_type = MSG_UNBLK_E;
              rv_n = 1'b1; rk_n = OP_WR; rd_n = wpend_q;
            end
          end
          ST_EI: if (in_type == MSG_WB_DONE || in_type == MSG_INV || in_type == MSG_INV_S) begin
            data_n = '0; st_n = ST_I; rv_n = 1'b1; rk_n = OP_EV;
          end
          default: ;
        endcase
      end
    end else if (take_cmd) begin
      case (cmd_op)
        OP_RD: if (st_q == ST_E) begin
          rv_n = 1'b1; rk_n = OP_RD; rd_n = data_q;
        end else begin
          ld = 1'b1; ld_type = MSG_REQ_S; st_n = ST_IS;
        end
        OP_WR: if (st_q == ST_E) begin
          data_n = cmd_wdata; rv_n = 1'b1; rk_n = OP_WR; rd_n = cmd_wdata;
        end else begin
          ld = 1'b1; ld_type = MSG_REQ_E; st_n = ST_IM;
          wpend_n = cmd_wdata; have_n = 1'b0;
        end
        OP_EV: if (st_q == ST_E) begin
          ld = 1'b1; ld_type = MSG_WBACK; st_n = ST_EI;
        end else begin
          data_n = '0; st_n = ST_I; rv_n = 1'b1; rk_n = OP_EV;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_I; fwd_q <= ST_I; data_q <= '0; wpend_q <= '0; have_q <= 1'b0;
      rsp_valid <= 1'b0; rsp_kind <= OP_RD; rsp_data <= '0;
    end else begin
      st_q <= st_n; fwd_q <= fwd_n; data_q <= data_n; wpend_q <= wpend_n; have_q <= have_n;
      rsp_valid <= rv_n; rsp_kind <= rk_n; rsp_data <= rd_n;
    end
  end

  // R4
  unblk_e_chk: assert property (@(posedge clk) disable iff (rst)
    ld && ld_type == MSG_UNBLK_E && in_type != MSG_DATA_C2C |-> ctr_nxt_zero);
  // R12
  e_wr_hit_chk: assert property (@(posedge clk) disable iff (rst)
    st_q == ST_E && take_cmd && cmd_op == OP_WR |=> rsp_valid && rsp_data == $past(cmd_wdata) && st_q == ST_E);
  // R9
  ei_cross_chk: assert property (@(posedge clk) disable iff (rst)
    st_q == ST_EI && take_msg && in_type == MSG_INV |=> st_q == ST_I && rsp_valid && rsp_kind == OP_EV);
  // R11
  pend_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IS || st_q == ST_IM || st_q == ST_EI) |-> !take_cmd);
endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl #(
  parameter int NCACHE = 4,
  parameter int DW     = 8,
  parameter int IDW    = $clog2(NCACHE + 1),
  parameter int CNTW   = $clog2(NCACHE + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [1:0]      cmd_op,
  input  logic [DW-1:0]   cmd_wdata,
  output logic            rsp_valid,
  output logic [1:0]      rsp_kind,
  output logic [DW-1:0]   rsp_data,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [3:0]      in_type,
  input  logic [IDW-1:0]  in_src,
  input  logic [DW-1:0]   in_data,
  input  logic [CNTW-1:0] in_cnt,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [3:0]      out_type,
  output logic [IDW-1:0]  out_dst,
  output logic [DW-1:0]   out_data
);
  localparam int DIR_ID = NCACHE;

  logic           ld, ctr_clr, ctr_sub, ctr_inc, ctr_nxt_zero;
  logic [3:0]     ld_type;
  logic [IDW-1:0] ld_dst;
  logic [DW-1:0]  ld_data;

  coh_line_fsm #(.DW(DW), .IDW(IDW), .DIR_ID(DIR_ID)) u_fsm (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_data(rsp_data),
    .in_valid(in_valid), .in_ready(in_ready), .in_type(in_type), .in_src(in_src), .in_data(in_data),
    .out_busy(out_valid),
    .ld(ld), .ld_type(ld_type), .ld_dst(ld_dst), .ld_data(ld_data),
    .ctr_clr(ctr_clr), .ctr_sub(ctr_sub), .ctr_inc(ctr_inc), .ctr_nxt_zero(ctr_nxt_zero)
  );

  coh_ack_ctr #(.CNTW(CNTW)) u_ctr (
    .clk(clk), .rst(rst), .clr(ctr_clr), .sub(ctr_sub), .inc(ctr_inc),
    .amt(in_cnt), .nxt_zero(ctr_nxt_zero)
  );

  coh_msg_out #(.IDW(IDW), .DW(DW)) u_out (
    .clk(clk), .rst(rst), .ld(ld), .ld_type(ld_type), .ld_dst(ld_dst), .ld_data(ld_data),
    .out_ready(out_ready), .out_valid(out_valid), .out_type(out_type),
    .out_dst(out_dst), .out_data(out_data)
  );
endmodule

// File: tb/sim_coh_line_ctrl.sv
module sim_coh_line_ctrl;
  localparam int NC = 4, DW = 8, IDW = 3, CNTW = 3;
  localparam int DIR = NC;

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_valid = 1'b0, in_valid = 1'b0, out_ready = 1'b0;
  logic [1:0] cmd_op = '0;
  logic [DW-1:0] cmd_wdata = '0, in_data = '0;
  logic [3:0] in_type = '0;
  logic [IDW-1:0] in_src = '0;
  logic [CNTW-1:0] in_cnt = '0;
  logic cmd_ready, rsp_valid, in_ready, out_valid;
  logic [1:0] rsp_kind;
  logic [DW-1:0] rsp_data, out_data;
  logic [3:0] out_type;
  logic [IDW-1:0] out_dst;

  int checks = 0, fails = 0, rsp_n = 0, exp_rsp = 0;
  logic [1:0] rk;
  logic [DW-1:0] rd;
  bit done = 1'b0;

  always #5 clk = ~clk;

  coh_line_ctrl #(.NCACHE(NC), .DW(DW), .IDW(IDW), .CNTW(CNTW)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_data(rsp_data),
    .in_valid(in_valid), .in_ready(in_ready), .in_type(in_type), .in_src(in_src),
    .in_data(in_data), .in_cnt(in_cnt), .out_valid(out_valid), .out_ready(out_ready),
    .out_type(out_type), .out_dst(out_dst), .out_data(out_data));

  always @(posedge clk) if (rsp_valid) begin
    rsp_n <= rsp_n + 1; rk <= rsp_kind; rd <= rsp_data;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [1:0] op, input logic [DW-1:0] wd, input string tag);
    @(negedge clk);
    for (int i = 0; i < 10 && !cmd_ready; i++) @(negedge clk);
    chk(cmd_ready, {tag, " cmd_ready"}, cmd_ready, 1);
    cmd_valid = 1'b1; cmd_op = op; cmd_wdata = wd;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic do_msg(input logic [3:0] t, input int src, input logic [DW-1:0] d,
                        input int cnt, input string tag);
    chk(in_ready, {tag, " in_ready"}, in_ready, 1);
    in_valid = 1'b1; in_type = t; in_src = IDW'(src); in_data = d; in_cnt = CNTW'(cnt);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic take_out(input logic [3:0] t, input int dst, input logic [DW-1:0] d,
                          input bit chkd, input string tag);
    for (int i = 0; i < 10 && !out_valid; i++) @(negedge clk);
    chk(out_valid, {tag, " out_valid"}, out_valid, 1);
    chk(out_type == t, {tag, " out_type"}, out_type, t);
    chk(out_dst == IDW'(dst), {tag, " out_dst"}, out_dst, dst);
    if (chkd) chk(out_data == d, {tag, " out_data"}, out_data, d);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic chk_rsp(input logic [1:0] k, input logic [DW-1:0] d, input string tag);
    @(negedge clk);
    exp_rsp++;
    chk(rsp_n == exp_rsp, {tag, " rsp count"}, rsp_n, exp_rsp);
    chk(rk == k, {tag, " rsp kind"}, rk, k);
    chk(rd == d, {tag, " rsp data"}, rd, d);
  endtask

  task automatic no_out(input string tag);
    chk(!out_valid, {tag, " no message"}, out_valid, 0);
  endtask

  // Write from I or S, completed by a directory reply with zero count, leaves E.
  task automatic to_e(input logic [DW-1:0] d);
    do_cmd(2'd1, d, "R3 setup");
    take_out(4'd2, DIR, '0, 1'b0, "R3 setup req");
    do_msg(4'd3, DIR, 8'h00, 0, "R3 setup data");
    take_out(4'd10, DIR, '0, 1'b0, "R3 setup unblk");
    chk_rsp(2'd1, d, "R3 setup");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(cmd_ready && in_ready, "R1 ready after reset", {cmd_ready, in_ready}, 3);
    chk(!out_valid && !rsp_valid, "R1 idle outputs", {out_valid, rsp_valid}, 0);

    // R2 read miss, then R11 gating
    do_cmd(2'd0, '0, "R2");
    chk(!cmd_ready, "R11 pending read blocks commands", cmd_ready, 0);
    take_out(4'd1, DIR, '0, 1'b0, "R2 request");
    chk(!cmd_ready, "R11 still pending", cmd_ready, 0);
    do_msg(4'd3, DIR, 8'hA5, 0, "R2 data");
    take_out(4'd9, DIR, '0, 1'b0, "R2 unblock");
    chk_rsp(2'd0, 8'hA5, "R2");

    // R7 silent evict in S then in I
    do_cmd(2'd2, '0, "R7 S");
    no_out("R7 S");
    chk_rsp(2'd2, 8'h00, "R7 S");
    do_cmd(2'd2, '0, "R7 I");
    no_out("R7 I");
    chk_rsp(2'd2, 8'h00, "R7 I");

    // R3/R4 sweep: every count and every split of early and late acknowledgments
    for (int n = 0; n < NC; n++) begin
      for (int early = 0; early <= n; early++) begin
        logic [DW-1:0] d;
        d = DW'(8'h30 + n * 8 + early);
        do_cmd(2'd1, d, "R4 write");
        take_out(4'd2, DIR, '0, 1'b0, "R4 request");
        for (int k = 0; k < early; k++) begin
          do_msg(4'd8, k, '0, 0, "R4 early ack");
          no_out("R4 early ack");
        end
        do_msg(4'd3, DIR, 8'h00, n, "R4 data");
        for (int k = early; k < n; k++) begin
          no_out("R4 before last ack");
          chk(rsp_n == exp_rsp, "R4 no response before last ack", rsp_n, exp_rsp);
          do_msg(4'd8, k, '0, 0, "R4 late ack");
        end
        take_out(4'd10, DIR, '0, 1'b0, "R4 unblock");
        chk_rsp(2'd1, d, "R4 complete");
        // R12 read hit in E
        do_cmd(2'd0, '0, "R12 read hit");
        no_out("R12 read hit");
        chk_rsp(2'd0, d, "R12 read hit");
        // R8 evict from E
        do_cmd(2'd2, '0, "R8 evict");
        take_out(4'd11, DIR, d, 1'b1, "R8 writeback");
        chk(!cmd_ready, "R11 writeback pending", cmd_ready, 0);
        do_msg(4'd12, DIR, '0, 0, "R8 done");
        no_out("R8 done");
        chk_rsp(2'd2, 8'h00, "R8 complete");
      end
    end

    // R12 write hit in E
    to_e(8'h11);
    do_cmd(2'd1, 8'h77, "R12 write hit");
    no_out("R12 write hit");
    chk_rsp(2'd1, 8'h77, "R12 write hit");
    do_cmd(2'd0, '0, "R12 read back");
    chk_rsp(2'd0, 8'h77, "R12 read back");

    // R6 Inv in E: peer data then owner data, then I
    do_msg(4'd6, 2, '0, 0, "R6 inv");
    chk(!in_ready, "R6 busy while forwarding", in_ready, 0);
    take_out(4'd4, 2, 8'h77, 1'b1, "R6 peer data");
    take_out(4'd5, DIR, 8'h77, 1'b1, "R6 owner data");
    do_cmd(2'd2, '0, "R6 now not E");
    no_out("R6 now not E");
    chk_rsp(2'd2, 8'h00, "R6 evict after inv");

    // R6 shared invalidate leaves S
    to_e(8'h5C);
    do_msg(4'd7, 1, '0, 0, "R6 invs");
    take_out(4'd4, 1, 8'h5C, 1'b1, "R6 invs peer data");
    take_out(4'd5, DIR, 8'h5C, 1'b1, "R6 invs owner data");
    do_cmd(2'd2, '0, "R6 silent evict from S");
    no_out("R6 silent evict from S");
    chk_rsp(2'd2, 8'h00, "R6 silent evict from S");

    // R13 hold while out_ready low; R10 read completed by peer data
    do_cmd(2'd0, '0, "R13");
    for (int i = 0; i < 3; i++) begin
      chk(out_valid && out_type == 4'd1, "R13 held type", out_type, 1);
      chk(out_dst == IDW'(DIR), "R13 held dst", out_dst, DIR);
      chk(!in_ready && !cmd_ready, "R13 inputs blocked", {in_ready, cmd_ready}, 0);
      @(negedge clk);
    end
    take_out(4'd1, DIR, '0, 1'b0, "R13 release");
    do_msg(4'd4, 3, 8'h99, 0, "R10 read peer data");
    take_out(4'd9, DIR, '0, 1'b0, "R10 unblock S");
    chk_rsp(2'd0, 8'h99, "R10 read");

    // R5 Inv in S and in I
    do_msg(4'd6, 2, '0, 0, "R5 S");
    take_out(4'd8, 2, '0, 1'b0, "R5 S ack");
    do_msg(4'd6, 1, '0, 0, "R5 I");
    take_out(4'd8, 1, '0, 1'b0, "R5 I ack");

    // R5 Inv during write wait, then completion
    do_cmd(2'd1, 8'hAB, "R5 IM");
    take_out(4'd2, DIR, '0, 1'b0, "R5 IM request");
    do_msg(4'd6, 3, '0, 0, "R5 IM inv");
    take_out(4'd8, 3, '0, 1'b0, "R5 IM ack");
    chk(rsp_n == exp_rsp, "R5 IM still pending", rsp_n, exp_rsp);
    do_msg(4'd3, DIR, 8'h00, 0, "R5 IM data");
    take_out(4'd10, DIR, '0, 1'b0, "R5 IM unblock");
    chk_rsp(2'd1, 8'hAB, "R5 IM complete");

    // R5 Inv during read wait
    do_msg(4'd6, 2, '0, 0, "R5 leave E");
    take_out(4'd4, 2, 8'hAB, 1'b1, "R5 leave E peer");
    take_out(4'd5, DIR, 8'hAB, 1'b1, "R5 leave E owner");
    do_cmd(2'd0, '0, "R5 IS");
    take_out(4'd1, DIR, '0, 1'b0, "R5 IS request");
    do_msg(4'd6, 0, '0, 0, "R5 IS inv");
    take_out(4'd8, 0, '0, 1'b0, "R5 IS ack");
    do_msg(4'd3, DIR, 8'h42, 0, "R5 IS data");
    take_out(4'd9, DIR, '0, 1'b0, "R5 IS unblock");
    chk_rsp(2'd0, 8'h42, "R5 IS complete");

    // R10 write completed by peer data with no acknowledgments
    do_cmd(2'd1, 8'hC3, "R10 write");
    take_out(4'd2, DIR, '0, 1'b0, "R10 request");
    do_msg(4'd4, 2, 8'h11, 0, "R10 peer data");
    take_out(4'd10, DIR, '0, 1'b0, "R10 unblock E");
    chk_rsp(2'd1, 8'hC3, "R10 write");
    do_cmd(2'd0, '0, "R10 hit after");
    no_out("R10 hit after");
    chk_rsp(2'd0, 8'hC3, "R10 hit after");

    // R9 Inv crossing the writeback
    do_cmd(2'd2, '0, "R9");
    take_out(4'd11, DIR, 8'hC3, 1'b1, "R9 writeback");
    do_msg(4'd6, 1, '0, 0, "R9 crossing inv");
    no_out("R9 crossing inv");
    chk_rsp(2'd2, 8'h00, "R9 complete");
    chk(cmd_ready, "R9 stable again", cmd_ready, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule